// File: doc/BRIEF.md
# External Memory Zone Controller

This block connects a word-addressed internal bus to an asynchronous external memory bus. Each request carries a 22-bit word address. The address is matched against five fixed address windows, called zones. On a hit, the block runs a three-phase access (lead, strobe, trail) on the external pins. Each zone has its own cycle counts for the three phases. Zones share chip-select pins: zones 0 and 1 drive one pin, zone 2 has a pin of its own, and the two upper zones drive a third pin. A device on a shared pin therefore answers in two address windows.

The uppermost zone is switched on by two things together: an external mode input and a configuration bit. An address that hits no enabled zone causes no external activity and returns an error. Each zone can also be set to stretch its strobe phase while the external device holds the ready input low.

The internal side offers a single request at a time. A request is taken only while the controller is idle. Completion is signalled by a one-cycle done pulse, which carries read data or an error flag.

Top module: `xmem_zone_ctrl`

## Requirements
- R1: The zone windows, as word addresses, are zone 0 = 0x002000..0x003FFF, zone 1 = 0x004000..0x005FFF, zone 2 = 0x080000..0x0FFFFF, zone 6 = 0x100000..0x17FFFF and zone 7 = 0x3FC000..0x3FFFFF. Configuration slot k of every per-zone vector (bits k*4+3..k*4 of the count vectors, bit k of `cfg_rdy_en_i`) belongs to zone 0, 1, 2, 6, 7 for k = 0, 1, 2, 3, 4.
- R2: Zones 0 and 1 pull `cs01_n_o` low, zone 2 pulls `cs2_n_o` low, and zones 6 and 7 pull `cs67_n_o` low. At most one select is low at any time, and a select is low only during an access to one of its zones.
- R3: Zone 7 is enabled only when `mode_pin_i` and `cfg_z7_en_i` are both 1. When zone 7 is disabled, its window is unmapped, but the zone 6 window still reaches `cs67_n_o`.
- R4: A request that hits no enabled zone keeps every select and strobe high. In the cycle after the request, `rsp_done_o` and `rsp_err_o` are both high for one cycle.
- R5: The select goes low in the cycle after the request is accepted and stays low for (setup+1)+(wait+1)+(hold+1) cycles, using the zone's counts. The strobe is low only in the middle wait+1 cycles.
- R6: When the zone's `cfg_rdy_en_i` bit is 1, the strobe phase continues past its last programmed cycle for as long as `xrdy_i` is low at a clock edge.
- R7: When the zone's `cfg_rdy_en_i` bit is 0, `xrdy_i` has no effect on the length of the strobe phase.
- R8: A read drives `xrd_n_o` low and captures `xd_i` at the edge that ends the strobe phase. In the first cycle after the select rises, `rsp_done_o` is high for one cycle with `rsp_err_o` low, and `rsp_rdata_o` shows the captured word.
- R9: A write drives `xwe_n_o` low in the strobe phase, holds `xrnw_o` low, and keeps `xd_oe_o` high with `xd_o` equal to the request data in every select-low cycle. Read and write strobes are never low together.
- R10: `xa_o` equals bits 18..0 of the request address and stays stable for the whole access.
- R11: A request made while an access is in progress is ignored. It produces no second access and no second done pulse.
- R12: After reset, all selects and strobes are high, `xrnw_o` is 1, `xd_oe_o` is 0 and `rsp_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, taken when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Internal word address |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Unmapped address, valid with done |
| rsp_rdata_o | output | 16 | Captured read word |
| mode_pin_i | input | 1 | External mode level for zone 7 |
| cfg_z7_en_i | input | 1 | Configuration bit for zone 7 |
| cfg_setup_i | input | 20 | Lead counts, 4 bits per zone slot |
| cfg_wait_i | input | 20 | Strobe counts, 4 bits per zone slot |
| cfg_hold_i | input | 20 | Trail counts, 4 bits per zone slot |
| cfg_rdy_en_i | input | 5 | Ready-stretch enable per zone slot |
| xa_o | output | 19 | External address |
| xd_o | output | 16 | External write data |
| xd_oe_o | output | 1 | Write data drive enable |
| xd_i | input | 16 | External read data |
| xrd_n_o | output | 1 | Read strobe, active low |
| xwe_n_o | output | 1 | Write strobe, active low |
| xrnw_o | output | 1 | Read/write level, 1 = read |
| xrdy_i | input | 1 | External ready |
| cs01_n_o | output | 1 | Shared select of zones 0 and 1 |
| cs2_n_o | output | 1 | Select of zone 2 |
| cs67_n_o | output | 1 | Shared select of zones 6 and 7 |

## Verification
The assertions assume that the configuration vectors and the zone-7 mode inputs do not change during an access. They also assume that `xd_i` is only meaningful while a read strobe is low. The stimulus changes configuration only while the controller is idle, and drives `xd_i` from a fixed function of `xa_o`. It issues a request only between accesses, except for one deliberate request during an access, which checks that such a request is ignored. `xrdy_i` changes only away from the clock edge, so each stretched strobe ends on a known cycle.

// File: rtl/xmz_pkg.sv
package xmz_pkg;

    parameter int XMZ_NZ  = 5;   // number of zone slots
    parameter int XMZ_TCW = 4;   // width of every phase count

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_ACT   = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PIN_NONE = 2'd0,
        PIN_01   = 2'd1,
        PIN_2    = 2'd2,
        PIN_67   = 2'd3
    } cs_pin_e;

    typedef struct packed {
        logic [XMZ_TCW-1:0] setup;
        logic [XMZ_TCW-1:0] waitc;
        logic [XMZ_TCW-1:0] hold;
        logic               rdy_en;
    } zone_tim_t;

    // first word of each zone slot
    function automatic logic [31:0] zone_base(input int z);
        case (z)
            0:       return 32'h0000_2000;
            1:       return 32'h0000_4000;
            2:       return 32'h0008_0000;
            3:       return 32'h0010_0000;
            default: return 32'h003F_C000;
        endcase
    endfunction

    // number of words in each zone slot
    function automatic logic [31:0] zone_words(input int z);
        case (z)
            0, 1:    return 32'h0000_2000;
            2, 3:    return 32'h0008_0000;
            default: return 32'h0000_4000;
        endcase
    endfunction

    // which select pin a zone slot drives
    function automatic cs_pin_e zone_pin(input int z);
        case (z)
            0, 1:    return PIN_01;
            2:       return PIN_2;
            default: return PIN_67;
        endcase
    endfunction

endpackage

// File: rtl/xmz_decode.sv
module xmz_decode
    import xmz_pkg::*;
#(
    parameter int IAW = 22,
    parameter int NZ  = XMZ_NZ,
    localparam int ZIW = $clog2(NZ)
) (
    input  logic [IAW-1:0] addr_i,
    input  logic           z7_en_i,
    output logic           hit_o,
    output logic [ZIW-1:0] zone_o,
    output cs_pin_e        pin_o
);
    logic [NZ-1:0] in_win;
    logic [31:0]   addr_w;

    assign addr_w = 32'(addr_i);

    for (genvar z = 0; z < NZ; z++) begin : g_win
        logic enabled;
        if (z == NZ - 1) begin : g_mode
            assign enabled = z7_en_i;
        end else begin : g_fixed
            assign enabled = 1'b1;
        end
        assign in_win[z] = enabled && (addr_w >= zone_base(z)) &&
                           (addr_w < zone_base(z) + zone_words(z));
    end

    always_comb begin
        hit_o  = 1'b0;
        zone_o = '0;
        pin_o  = PIN_NONE;
        for (int z = 0; z < NZ; z++) begin
            if (in_win[z] && !hit_o) begin
                hit_o  = 1'b1;
                zone_o = ZIW'(z);
                pin_o  = zone_pin(z);
            end
        end
    end
endmodule

// File: rtl/xmz_seq.sv
module xmz_seq
    import xmz_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       req_i,
    input  logic       hit_i,
    input  zone_tim_t  tim_i,
    input  logic       xrdy_i,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       capture_o,
    output logic       done_o,
    output logic       err_o
);
    seq_state_e         st_q;
    zone_tim_t          tim_q;
    logic [XMZ_TCW-1:0] cnt_q;
    logic               stall;

    assign state_o   = st_q;
    assign accept_o  = (st_q == ST_IDLE) && req_i && hit_i;
    assign stall     = tim_q.rdy_en && !xrdy_i;
    assign capture_o = (st_q == ST_ACT) && (cnt_q == '0) && !stall;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            tim_q  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_i) begin
                        if (hit_i) begin
                            st_q  <= ST_LEAD;
                            tim_q <= tim_i;
                            cnt_q <= tim_i.setup;
                        end else begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end
                    end
                end
                ST_LEAD: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_ACT;
                        cnt_q <= tim_q.waitc;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_ACT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!stall) begin
                        st_q  <= ST_TRAIL;
                        cnt_q <= tim_q.hold;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        st_q   <= ST_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/xmem_zone_ctrl.sv
module xmem_zone_ctrl
    import xmz_pkg::*;
#(
    parameter int IAW = 22,
    parameter int XAW = 19,
    parameter int DW  = 16,
    localparam int NZ  = XMZ_NZ,
    localparam int TCW = XMZ_TCW,
    localparam int ZIW = $clog2(NZ)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [IAW-1:0]    req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    output logic              rsp_done_o,
    output logic              rsp_err_o,
    output logic [DW-1:0]     rsp_rdata_o,
    input  logic              mode_pin_i,
    input  logic              cfg_z7_en_i,
    input  logic [NZ*TCW-1:0] cfg_setup_i,
    input  logic [NZ*TCW-1:0] cfg_wait_i,
    input  logic [NZ*TCW-1:0] cfg_hold_i,
    input  logic [NZ-1:0]     cfg_rdy_en_i,
    output logic [XAW-1:0]    xa_o,
    output logic [DW-1:0]     xd_o,
    output logic              xd_oe_o,
    input  logic [DW-1:0]     xd_i,
    output logic              xrd_n_o,
    output logic              xwe_n_o,
    output logic              xrnw_o,
    input  logic              xrdy_i,
    output logic              cs01_n_o,
    output logic              cs2_n_o,
    output logic              cs67_n_o
);
    logic           hit;
    logic [ZIW-1:0] zone;
    cs_pin_e        pin;
    zone_tim_t      sel_tim;
    seq_state_e     st;
    logic           accept, capture, busy;

    logic [XAW-1:0] addr_q;
    logic [DW-1:0]  wdata_q, rdata_q;
    logic           we_q;
    cs_pin_e        pin_q;

    xmz_decode #(.IAW(IAW), .NZ(NZ)) dec_i (
        .addr_i  (req_addr_i),
        .z7_en_i (mode_pin_i & cfg_z7_en_i),
        .hit_o   (hit),
        .zone_o  (zone),
        .pin_o   (pin)
    );

    always_comb begin
        sel_tim = '0;
        for (int z = 0; z < NZ; z++) begin
            if (zone == ZIW'(z)) begin
                sel_tim.setup  = cfg_setup_i[z*TCW +: TCW];
                sel_tim.waitc  = cfg_wait_i[z*TCW +: TCW];
                sel_tim.hold   = cfg_hold_i[z*TCW +: TCW];
                sel_tim.rdy_en = cfg_rdy_en_i[z];
            end
        end
    end

    xmz_seq seq_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .req_i     (req_i),
        .hit_i     (hit),
        .tim_i     (sel_tim),
        .xrdy_i    (xrdy_i),
        .state_o   (st),
        .accept_o  (accept),
        .capture_o (capture),
        .done_o    (rsp_done_o),
        .err_o     (rsp_err_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            pin_q   <= PIN_NONE;
        end else begin
            if (accept) begin
                addr_q  <= req_addr_i[XAW-1:0];
                wdata_q <= req_wdata_i;
                we_q    <= req_we_i;
                pin_q   <= pin;
            end
            if (capture && !we_q) begin
                rdata_q <= xd_i;
            end
        end
    end

    assign busy        = (st != ST_IDLE);
    assign rsp_rdata_o = rdata_q;
    assign xa_o        = addr_q;
    assign xd_o        = wdata_q;
    assign xd_oe_o     = busy && we_q;
    assign xrnw_o      = !(busy && we_q);
    assign xrd_n_o     = !((st == ST_ACT) && !we_q);
    assign xwe_n_o     = !((st == ST_ACT) && we_q);
    assign cs01_n_o    = !(busy && (pin_q == PIN_01));
    assign cs2_n_o     = !(busy && (pin_q == PIN_2));
    assign cs67_n_o    = !(busy && (pin_q == PIN_67));
endmodule

// File: rtl/xmz_checker.sv
module xmz_checker #(
    parameter int XAW = 19
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           cs01_n,
    input logic           cs2_n,
    input logic           cs67_n,
    input logic           xrd_n,
    input logic           xwe_n,
    input logic           xrnw,
    input logic           xd_oe,
    input logic [XAW-1:0] xa,
    input logic           done,
    input logic           err
);
    logic cs_low;
    assign cs_low = !cs01_n || !cs2_n || !cs67_n;

    assert_one_select_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({!cs01_n, !cs2_n, !cs67_n}));

    assert_err_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        err |-> (done && !cs_low && xrd_n && xwe_n));

    assert_strobe_in_select_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!xrd_n || !xwe_n) |-> cs_low);

    assert_done_after_select_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (done && !err) |-> ($past(cs_low) && !cs_low));

    assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(!xrd_n && !xwe_n));

    assert_write_drive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !xwe_n |-> (xd_oe && !xrnw));

    assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_low && $past(cs_low)) |-> $stable(xa));
endmodule

bind xmem_zone_ctrl xmz_checker #(.XAW(XAW)) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cs01_n (cs01_n_o),
    .cs2_n  (cs2_n_o),
    .cs67_n (cs67_n_o),
    .xrd_n  (xrd_n_o),
    .xwe_n  (xwe_n_o),
    .xrnw   (xrnw_o),
    .xd_oe  (xd_oe_o),
    .xa     (xa_o),
    .done   (rsp_done_o),
    .err    (rsp_err_o)
);

// File: tb/xmem_zone_ctrl_tb.sv
module xmem_zone_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, req_we_i = 1'b0;
    logic [21:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        rsp_done_o, rsp_err_o;
    logic [15:0] rsp_rdata_o;
    logic        mode_pin_i = 1'b1, cfg_z7_en_i = 1'b1;
    logic [19:0] cfg_setup_i, cfg_wait_i, cfg_hold_i;
    logic [4:0]  cfg_rdy_en_i = 5'b00110;
    logic [18:0] xa_o;
    logic [15:0] xd_o, xd_i;
    logic        xd_oe_o, xrd_n_o, xwe_n_o, xrnw_o;
    logic        xrdy_i = 1'b1;
    logic        cs01_n_o, cs2_n_o, cs67_n_o;

    always #10 clk = ~clk;   // 50 MHz

    int setup_t[5] = '{0, 1, 2, 0, 1};
    int wait_t[5]  = '{1, 2, 3, 0, 1};
    int hold_t[5]  = '{1, 0, 2, 1, 0};

    always_comb begin
        for (int z = 0; z < 5; z++) begin
            cfg_setup_i[z*4 +: 4] = 4'(setup_t[z]);
            cfg_wait_i[z*4 +: 4]  = 4'(wait_t[z]);
            cfg_hold_i[z*4 +: 4]  = 4'(hold_t[z]);
        end
    end

    function automatic logic [15:0] mem_word(input logic [18:0] a);
        return a[15:0] ^ {a[18:16], 13'h0} ^ 16'h5A3C;
    endfunction
    assign xd_i = mem_word(xa_o);

    xmem_zone_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .req_i(req_i), .req_we_i(req_we_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .rsp_done_o(rsp_done_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
        .mode_pin_i(mode_pin_i), .cfg_z7_en_i(cfg_z7_en_i),
        .cfg_setup_i(cfg_setup_i), .cfg_wait_i(cfg_wait_i), .cfg_hold_i(cfg_hold_i),
        .cfg_rdy_en_i(cfg_rdy_en_i), .xa_o(xa_o), .xd_o(xd_o), .xd_oe_o(xd_oe_o),
        .xd_i(xd_i), .xrd_n_o(xrd_n_o), .xwe_n_o(xwe_n_o), .xrnw_o(xrnw_o),
        .xrdy_i(xrdy_i), .cs01_n_o(cs01_n_o), .cs2_n_o(cs2_n_o), .cs67_n_o(cs67_n_o)
    );

    int checks = 0, fails = 0, done_count = 0, rdy_low = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        int          pin;    // 0 none, 1 pin01, 2 pin2, 3 pin67
        int          lead, act, trail;
        bit          err, we;
        logic [18:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // monitor
    bit          in_acc = 0, addr_bad = 0, oe_bad = 0, wd_bad = 0, dir_bad = 0;
    int          m_pin = 0, n_lead = 0, n_act = 0, n_trail = 0, n_rd = 0, n_wr = 0;
    logic [18:0] a_first = '0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit low = !cs01_n_o || !cs2_n_o || !cs67_n_o;
            automatic bit stb = !xrd_n_o || !xwe_n_o;
            if (low) begin
                if (!in_acc) begin
                    in_acc = 1; a_first = xa_o;
                    m_pin = !cs01_n_o ? 1 : (!cs2_n_o ? 2 : 3);
                end
                if (xa_o != a_first) addr_bad = 1;
                if (stb) n_act++;
                else if (n_act == 0) n_lead++;
                else n_trail++;
                if (!xrd_n_o) n_rd++;
                if (!xwe_n_o) n_wr++;
                if (sb.size() != 0) begin
                    if (sb[0].we && (!xd_oe_o || xd_o != sb[0].data || xrnw_o)) wd_bad = 1;
                    if (!sb[0].we && (xd_oe_o || !xrnw_o)) oe_bad = 1;
                end
            end
            xrdy_i <= stb ? (n_act >= rdy_low) : 1'b1;
            if (rsp_done_o) begin
                done_count++;
                if (sb.size() == 0) begin
                    chk(0, "R11 unexpected done", 1, 0);
                end else begin
                    automatic exp_t e = sb.pop_front();
                    chk(rsp_err_o == e.err, {e.tag, " err"}, rsp_err_o, e.err);
                    chk(m_pin == e.pin, {e.tag, " pin"}, m_pin, e.pin);
                    if (!e.err) begin
                        chk(n_lead == e.lead, {e.tag, " R5 lead"}, n_lead, e.lead);
                        chk(n_act == e.act, {e.tag, " R5 strobe"}, n_act, e.act);
                        chk(n_trail == e.trail, {e.tag, " R5 trail"}, n_trail, e.trail);
                        chk(a_first == e.addr && !addr_bad, {e.tag, " R10 addr"}, a_first, e.addr);
                        if (e.we) begin
                            chk(n_wr == e.act && n_rd == 0 && !wd_bad, {e.tag, " R9 write"}, n_wr, e.act);
                        end else begin
                            chk(n_rd == e.act && n_wr == 0 && !oe_bad, {e.tag, " R8 rd strobe"}, n_rd, e.act);
                            chk(rsp_rdata_o == e.data, {e.tag, " R8 rdata"}, rsp_rdata_o, e.data);
                        end
                    end
                end
                in_acc = 0; addr_bad = 0; oe_bad = 0; wd_bad = 0;
                m_pin = 0; n_lead = 0; n_act = 0; n_trail = 0; n_rd = 0; n_wr = 0;
            end
        end
    end

    function automatic int zone_of(input logic [21:0] a, input bit z7);
        if (a >= 22'h2000 && a < 22'h4000) return 0;
        if (a >= 22'h4000 && a < 22'h6000) return 1;
        if (a >= 22'h80000 && a < 22'h100000) return 2;
        if (a >= 22'h100000 && a < 22'h180000) return 3;
        if (z7 && a >= 22'h3FC000) return 4;
        return -1;
    endfunction

    task automatic access(input logic [21:0] a, input bit we, input logic [15:0] wd,
                          input int rl, input bit intrude, input string tag);
        automatic int z = zone_of(a, mode_pin_i && cfg_z7_en_i);
        automatic exp_t e;
        automatic int d0 = done_count;
        e.tag = tag; e.we = we; e.addr = a[18:0];
        e.err = (z < 0);
        e.pin = (z < 0) ? 0 : (z < 2 ? 1 : (z == 2 ? 2 : 3));
        if (z >= 0) begin
            e.lead = setup_t[z] + 1;
            e.act = wait_t[z] + 1;
            if (cfg_rdy_en_i[z] && rl > e.act) e.act = rl;
            e.trail = hold_t[z] + 1;
        end
        e.data = we ? wd : mem_word(a[18:0]);
        @(negedge clk);
        rdy_low = rl;
        sb.push_back(e);
        req_i = 1; req_we_i = we; req_addr_i = a; req_wdata_i = wd;
        @(negedge clk);
        req_i = 0;
        if (intrude) begin
            @(negedge clk);
            req_i = 1; req_we_i = 1; req_addr_i = 22'h2010; req_wdata_i = 16'hDEAD;
            @(negedge clk);
            req_i = 0;
        end
        while (done_count == d0) @(negedge clk);
        rdy_low = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state, sampled while reset is still applied
        chk(cs01_n_o && cs2_n_o && cs67_n_o && xrd_n_o && xwe_n_o, "R12 idle pins", 0, 1);
        chk(xrnw_o && !xd_oe_o && !rsp_done_o, "R12 idle levels", 0, 1);
        @(negedge clk); rst = 0;

        // R1 R2 R5 R8 R10: reads in every window, including edges
        access(22'h002005, 0, 0, 0, 0, "R1 z0 read");
        access(22'h005FFF, 0, 0, 0, 0, "R1 z1 top read");
        access(22'h080000, 0, 0, 0, 0, "R1 z2 base read");
        access(22'h17FFFF, 0, 0, 0, 0, "R2 z6 top read");
        access(22'h3FC010, 0, 0, 0, 0, "R2 z7 read");
        // R9 writes
        access(22'h003FFF, 1, 16'h1234, 0, 0, "R9 z0 write");
        access(22'h004000, 1, 16'hA5A5, 0, 0, "R9 z1 write");
        access(22'h0C1234, 1, 16'h0F0F, 0, 0, "R9 z2 write");
        access(22'h3FFFFF, 1, 16'hBEEF, 0, 0, "R9 z7 write");
        // R4 unmapped addresses next to every window
        access(22'h001FFF, 0, 0, 0, 0, "R4 below z0");
        access(22'h006000, 0, 0, 0, 0, "R4 above z1");
        access(22'h07FFFF, 1, 16'h1111, 0, 0, "R4 below z2");
        access(22'h180000, 0, 0, 0, 0, "R4 above z6");
        access(22'h3FBFFF, 0, 0, 0, 0, "R4 below z7");
        access(22'h000000, 0, 0, 0, 0, "R4 zero");
        // R3 zone 7 gated by the mode pin and the configuration bit
        @(negedge clk); mode_pin_i = 0;
        access(22'h3FC010, 0, 0, 0, 0, "R3 z7 pin off");
        access(22'h100123, 0, 0, 0, 0, "R3 z6 still on");
        @(negedge clk); mode_pin_i = 1; cfg_z7_en_i = 0;
        access(22'h3FD000, 1, 16'h2222, 0, 0, "R3 z7 bit off");
        @(negedge clk); cfg_z7_en_i = 1;
        access(22'h3FD000, 0, 0, 0, 0, "R3 z7 back on");
        // R6 ready stretch, R7 ready ignored
        access(22'h0A0000, 0, 0, 6, 0, "R6 z2 stretch");
        access(22'h004321, 1, 16'h3333, 2, 0, "R6 z1 early ready");
        access(22'h004321, 0, 0, 7, 0, "R6 z1 stretch");
        access(22'h002222, 0, 0, 5, 0, "R7 z0 ready ignored");
        access(22'h100000, 1, 16'h4444, 4, 0, "R7 z6 ready ignored");
        // R11 request during an access is ignored
        access(22'h090000, 0, 0, 0, 1, "R11 busy");
        begin
            automatic int d1 = done_count;
            automatic bit quiet = 1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!cs01_n_o || !cs2_n_o || !cs67_n_o) quiet = 0;
            end
            chk(quiet && done_count == d1, "R11 no extra access", done_count, d1);
        end
        chk(sb.size() == 0, "R8 all done pulses seen", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule